// File: doc/BRIEF.md
# SONET Transmit Line Alarm Inserter

This block sits in a byte-serial STS-3 transmit path, one byte per clock, and rewrites the outgoing stream according to an 8-bit control word. A single-cycle marker on the input flags the first byte of each 9 x 270 byte frame. The first 9 columns of each frame are transport overhead. Rows 1 to 3 of that overhead are section overhead. Rows 4 to 9 are line overhead, and the pointer row is one of them. Every other byte is envelope capacity.

Under control it can zero the whole stream to emulate a lost signal, fill the line layer with ones to raise line AIS, set the line remote-defect code in K2, and run a frame-synchronous scrambler. It can also corrupt, once per request, the first framing byte or the first B2 parity byte. The control word is taken only at a frame boundary, so every frame is sent under one consistent setting. Output and frame marker leave through one register stage.

Top module: `sonet_line_alarm_ins`

## Requirements
- R1: While reset is asserted, `outByte` is 0x00 and `outFrameStart` is 0.
- R2: With control 0x00 every byte passes unchanged with a latency of one clock, and `outFrameStart` is high for exactly the output byte at frame position row 1, column 1.
- R3: Control bit 3 (force loss of signal) set makes every output byte of the frame 0x00.
- R4: Bit 3 dominates. With control 0xFF every byte is still 0x00, whatever bits 0, 1, 2, 4 and 5 request.
- R5: Bit 4 (force line AIS) set, with bit 3 clear, sends 0xFF in every line overhead byte (rows 4 to 9, columns 1 to 9) and every envelope byte (columns 10 to 270 of all rows).
- R6: While bit 4 is set, the section overhead bytes (rows 1 to 3, columns 1 to 9) pass unchanged.
- R7: Bit 5 (force line RDI) replaces the three least significant bits of the first K2 byte (row 5, column 7) with binary 110 and keeps its upper five bits. It has no effect when bit 4 is also set.
- R8: Bit 2 (scramble) XORs every byte except row 1, columns 1 to 9 with the sequence of x^7+x^6+1. That sequence is seeded all ones at row 1, column 10, is taken MSB first, and begins 0xFE, 0x04.
- R9: When bit 4 and bit 2 are both set, the scrambler acts on the AIS-filled bytes, so line and envelope bytes go out as 0xFF XOR the sequence.
- R10: A 0-to-1 change of bit 0 inverts all eight bits of the first A1 byte (row 1, column 1) in exactly one frame. Other framing bytes are unchanged.
- R11: A 0-to-1 change of bit 1 inverts only the least significant bit of the first B2 byte (row 5, column 1) in exactly one frame.
- R12: The control word is sampled only at the frame-start byte. A change in mid-frame affects nothing before the next frame.
- R13: Bits 7 and 6 of the control word have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| inByte | input | 8 | Incoming transmit byte |
| inFrameStart | input | 1 | High on the first byte of a frame |
| ctrlReg | input | 8 | Alarm and insertion control word |
| outByte | output | 8 | Outgoing byte, one clock after input |
| outFrameStart | output | 1 | Frame marker aligned with `outByte` |

## Verification
Scrambling and line AIS can act on the same byte. This is provoked by setting both bits, and the result is judged over a whole frame: envelope and line bytes must be 0xFF XOR the bench's own bit-serial sequence, the scrambled section rows must be the data XOR the sequence, and the framing row must be untouched. Loss of signal meeting every other control in one frame is provoked with control 0xFF, and the judgement is an all-zero frame. A mid-frame change to loss of signal checks that the running frame finishes under the old setting.

// File: rtl/sonet_alarm_pkg.sv
package sonet_alarm_pkg;

  localparam int SCR_W = 7;

  // control word bit positions
  localparam int CB_ERR_A1 = 0;
  localparam int CB_ERR_B2 = 1;
  localparam int CB_SCR    = 2;
  localparam int CB_LOS    = 3;
  localparam int CB_AIS    = 4;
  localparam int CB_RDI    = 5;

  // per-frame settings latched at the frame boundary
  typedef struct packed {
    logic los;
    logic ais;
    logic rdi;
    logic scr;
    logic errA1;
    logic errB2;
  } cmd_t;

  // per-byte position strobes
  typedef struct packed {
    logic soh;       // section overhead byte
    logic firstA1;   // first framing byte
    logic firstB2;   // first line parity byte
    logic firstK2;   // first K2 byte
    logic noScr;     // framing row overhead, never scrambled
    logic scrLoad;   // first scrambled byte, seed point
  } pos_t;

  typedef struct packed {
    logic [7:0]       key;
    logic [SCR_W-1:0] next;
  } scr_step_t;

  // eight serial steps of x^7 + x^6 + 1, MSB of the byte first
  function automatic scr_step_t scrStep(input logic [SCR_W-1:0] s);
    scr_step_t r;
    logic [SCR_W-1:0] st;
    st = s;
    for (int i = 7; i >= 0; i--) begin
      r.key[i] = st[SCR_W-1];
      st = {st[SCR_W-2:0], st[SCR_W-1] ^ st[SCR_W-2]};
    end
    r.next = st;
    return r;
  endfunction

endpackage

// File: rtl/sla_ctrl.sv
module sla_ctrl
  import sonet_alarm_pkg::*;
#(
  parameter int ROWS       = 9,
  parameter int COLS       = 270,
  parameter int TOH_COLS   = 9,
  parameter int SOH_ROWS   = 3,
  parameter int INTERLEAVE = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inFrameStart,
  input  logic [7:0] ctrlReg,
  output cmd_t       cmd,
  output pos_t       pos
);

  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);
  localparam int B2_ROW = SOH_ROWS + 1;
  localparam int K2_COL = 2 * INTERLEAVE;

  logic [ROW_W-1:0] lastRow, curRow;
  logic [COL_W-1:0] lastCol, curCol;
  logic [1:0]       ctrlPrev;
  logic             pendA1, pendB2;
  logic             riseA1, riseB2;
  cmd_t             cmdHeld, cmdFresh;
  logic             unusedCtrl;

  assign unusedCtrl = ^ctrlReg[7:6];

  // position of the byte now at the input
  always_comb begin
    if (inFrameStart) begin
      curRow = '0;
      curCol = '0;
    end else if (lastCol == COL_W'(COLS - 1)) begin
      curCol = '0;
      curRow = (lastRow == ROW_W'(ROWS - 1)) ? '0 : lastRow + 1'b1;
    end else begin
      curCol = lastCol + 1'b1;
      curRow = lastRow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastRow <= ROW_W'(ROWS - 1);
      lastCol <= COL_W'(COLS - 1);
    end else begin
      lastRow <= curRow;
      lastCol <= curCol;
    end
  end

  always_comb begin
    pos.soh     = (curRow < ROW_W'(SOH_ROWS)) && (curCol < COL_W'(TOH_COLS));
    pos.firstA1 = (curRow == '0) && (curCol == '0);
    pos.firstB2 = (curRow == ROW_W'(B2_ROW)) && (curCol == '0);
    pos.firstK2 = (curRow == ROW_W'(B2_ROW)) && (curCol == COL_W'(K2_COL));
    pos.noScr   = (curRow == '0) && (curCol < COL_W'(TOH_COLS));
    pos.scrLoad = (curRow == '0) && (curCol == COL_W'(TOH_COLS));
  end

  // one-shot error requests: a rising control bit arms one frame
  assign riseA1 = ctrlReg[CB_ERR_A1] & ~ctrlPrev[0];
  assign riseB2 = ctrlReg[CB_ERR_B2] & ~ctrlPrev[1];

  always_comb begin
    cmdFresh.los   = ctrlReg[CB_LOS];
    cmdFresh.ais   = ctrlReg[CB_AIS];
    cmdFresh.rdi   = ctrlReg[CB_RDI];
    cmdFresh.scr   = ctrlReg[CB_SCR];
    cmdFresh.errA1 = pendA1 | riseA1;
    cmdFresh.errB2 = pendB2 | riseB2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlPrev <= '0;
      pendA1   <= 1'b0;
      pendB2   <= 1'b0;
      cmdHeld  <= '0;
    end else begin
      ctrlPrev <= {ctrlReg[CB_ERR_B2], ctrlReg[CB_ERR_A1]};
      if (inFrameStart) begin
        cmdHeld <= cmdFresh;
        pendA1  <= 1'b0;
        pendB2  <= 1'b0;
      end else begin
        pendA1 <= pendA1 | riseA1;
        pendB2 <= pendB2 | riseB2;
      end
    end
  end

  assign cmd = inFrameStart ? cmdFresh : cmdHeld;

  // R12: settings do not move inside a frame
  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !inFrameStart |=> $stable(cmdHeld));

endmodule

// File: rtl/sla_scrambler.sv
module sla_scrambler
  import sonet_alarm_pkg::*;
#(
  parameter logic [SCR_W-1:0] SEED = '1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scrLoad,
  input  logic       scrAdvance,
  output logic [7:0] key
);

  logic [SCR_W-1:0] state, curState;
  scr_step_t        step;

  assign curState = scrLoad ? SEED : state;
  assign step     = scrStep(curState);
  assign key      = step.key;

  always_ff @(posedge clk) begin
    if (!rstN)           state <= SEED;
    else if (scrAdvance) state <= step.next;
  end

endmodule

// File: rtl/sla_datapath.sv
module sla_datapath
  import sonet_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inByte,
  input  logic       inFrameStart,
  input  cmd_t       cmd,
  input  pos_t       pos,
  input  logic [7:0] key,
  output logic [7:0] outByte,
  output logic       outFrameStart
);

  logic [7:0] nextByte;

  // order: error insertion, RDI, AIS fill, scrambling, loss override
  always_comb begin
    nextByte = inByte;
    if (pos.firstA1 && cmd.errA1) nextByte = ~nextByte;
    if (pos.firstB2 && cmd.errB2) nextByte[0] = ~nextByte[0];
    if (pos.firstK2 && cmd.rdi && !cmd.ais) nextByte[2:0] = 3'b110;
    if (cmd.ais && !pos.soh) nextByte = 8'hFF;
    if (cmd.scr && !pos.noScr) nextByte = nextByte ^ key;
    if (cmd.los) nextByte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outByte       <= 8'h00;
      outFrameStart <= 1'b0;
    end else begin
      outByte       <= nextByte;
      outFrameStart <= inFrameStart;
    end
  end

  // R3: loss of signal zeroes the next output
  p_los_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.los |=> outByte == 8'h00);

  // R5: line and envelope bytes filled with ones
  p_ais_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.ais && !cmd.los && !cmd.scr && !pos.soh |=> outByte == 8'hFF);

  // R6: section overhead passes under AIS
  p_soh_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.ais && !cmd.los && !cmd.scr && pos.soh && !(pos.firstA1 && cmd.errA1)
    |=> outByte == $past(inByte));

  // R7: remote defect code in K2
  p_rdi_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rdi && !cmd.ais && !cmd.los && !cmd.scr && pos.firstK2
    |=> outByte[2:0] == 3'b110);

endmodule

// File: rtl/sonet_line_alarm_ins.sv
module sonet_line_alarm_ins
  import sonet_alarm_pkg::*;
#(
  parameter int ROWS       = 9,
  parameter int COLS       = 270,
  parameter int TOH_COLS   = 9,
  parameter int SOH_ROWS   = 3,
  parameter int INTERLEAVE = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inByte,
  input  logic       inFrameStart,
  input  logic [7:0] ctrlReg,
  output logic [7:0] outByte,
  output logic       outFrameStart
);

  cmd_t       cmd;
  pos_t       pos;
  logic [7:0] key;

  sla_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .TOH_COLS(TOH_COLS),
    .SOH_ROWS(SOH_ROWS), .INTERLEAVE(INTERLEAVE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inFrameStart(inFrameStart),
    .ctrlReg(ctrlReg), .cmd(cmd), .pos(pos)
  );

  sla_scrambler #(.SEED('1)) u_scr (
    .clk(clk), .rstN(rstN), .scrLoad(pos.scrLoad),
    .scrAdvance(!pos.noScr), .key(key)
  );

  sla_datapath u_dp (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inFrameStart(inFrameStart),
    .cmd(cmd), .pos(pos), .key(key),
    .outByte(outByte), .outFrameStart(outFrameStart)
  );

endmodule

// File: tb/sonet_line_alarm_ins_tb.sv
`timescale 1ns/1ps
module sonet_line_alarm_ins_tb;

  localparam int ROWS  = 9;
  localparam int COLS  = 270;
  localparam int FRAME = ROWS * COLS;
  localparam int NSCR  = FRAME - 9;
  localparam logic [7:0] DATA = 8'hA5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic       inFrameStart = 1'b0;
  logic [7:0] ctrlReg = 8'h00;
  logic [7:0] outByte;
  logic       outFrameStart;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  always #4 clk = ~clk;

  sonet_line_alarm_ins u_dut (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inFrameStart(inFrameStart),
    .ctrlReg(ctrlReg), .outByte(outByte), .outFrameStart(outFrameStart)
  );

  // capture buffers
  logic [7:0] capBuf  [0:FRAME-1];
  bit         capFs   [0:FRAME-1];
  logic [7:0] doneBuf [0:FRAME-1];
  bit         doneFs  [0:FRAME-1];
  int         framesDone = 0;
  logic [7:0] keyRef  [0:NSCR-1];

  // independent sequence: b[n] = b[n-6] ^ b[n-7], first seven ones
  initial begin
    bit bits [0:NSCR*8-1];
    for (int n = 0; n < NSCR * 8; n++)
      bits[n] = (n < 7) ? 1'b1 : (bits[n-6] ^ bits[n-7]);
    for (int k = 0; k < NSCR; k++)
      for (int b = 0; b < 8; b++)
        keyRef[k][7-b] = bits[k*8+b];
  end

  // stream driver and output capture
  initial begin
    int  drvIdx = FRAME - 1;
    int  prevIdx = 0;
    bit  prevValid = 0;
    forever begin
      @(negedge clk);
      if (prevValid) begin
        capBuf[prevIdx] = outByte;
        capFs[prevIdx]  = outFrameStart;
        if (prevIdx == FRAME - 1) begin
          doneBuf = capBuf;
          doneFs  = capFs;
          framesDone++;
        end
      end
      if (rstN) begin
        drvIdx       = (drvIdx + 1) % FRAME;
        inByte       = DATA;
        inFrameStart = (drvIdx == 0);
        prevIdx      = drvIdx;
        prevValid    = 1;
      end else begin
        inByte       = DATA;
        inFrameStart = 1'b0;
        prevValid    = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp,
                     input string what);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", tag, what, act, exp);
    end
  endtask

  task automatic waitFrames(input int n);
    int target = framesDone + n;
    while (framesDone < target) @(negedge clk);
  endtask

  // change control away from the frame boundary, then let one full frame run
  task automatic applyCtrl(input logic [7:0] v);
    repeat (10) @(negedge clk);
    ctrlReg = v;
    waitFrames(2);
  endtask

  function automatic int idxOf(input int r, input int c);
    return r * COLS + c;
  endfunction

  typedef struct packed {
    logic [7:0] ctrl;
    int         row;
    int         col;
    logic [7:0] exp;
    int         tag;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [0:NV-1] = '{
    '{8'h00, 0,   0, 8'hA5, 2},   // R2 passthrough
    '{8'h00, 4,   6, 8'hA5, 2},   // R2
    '{8'h00, 8, 269, 8'hA5, 2},   // R2
    '{8'h08, 0,   0, 8'h00, 3},   // R3 loss zeroes
    '{8'h08, 5, 100, 8'h00, 3},   // R3
    '{8'hFF, 0,   0, 8'h00, 4},   // R4 loss dominates
    '{8'hFF, 4,   6, 8'h00, 4},   // R4
    '{8'hFF, 2,  50, 8'h00, 4},   // R4
    '{8'h10, 3,   0, 8'hFF, 5},   // R5 pointer row
    '{8'h10, 0,  20, 8'hFF, 5},   // R5 envelope row 1
    '{8'h10, 8,   8, 8'hFF, 5},   // R5 last line overhead
    '{8'h10, 2,   8, 8'hA5, 6},   // R6 section overhead kept
    '{8'h10, 0,   0, 8'hA5, 6},   // R6
    '{8'h10, 1,   4, 8'hA5, 6},   // R6
    '{8'h20, 4,   6, 8'hA6, 7},   // R7 K2 code 110
    '{8'h20, 4,   5, 8'hA5, 7},   // R7 neighbour
    '{8'h20, 4,   7, 8'hA5, 7},   // R7 neighbour
    '{8'h20, 5,   6, 8'hA5, 7},   // R7 next row
    '{8'h30, 4,   6, 8'hFF, 7},   // R7 suppressed by AIS
    '{8'h30, 2,   6, 8'hA5, 6},   // R6
    '{8'h04, 0,   9, 8'h5B, 8},   // R8 first key 0xFE
    '{8'h04, 0,  10, 8'hA1, 8},   // R8 second key 0x04
    '{8'h04, 0,   8, 8'hA5, 8},   // R8 framing row unscrambled
    '{8'h04, 0,   0, 8'hA5, 8},   // R8
    '{8'hC0, 0,   0, 8'hA5, 13},  // R13 upper bits inert
    '{8'hC0, 4,   6, 8'hA5, 13},  // R13
    '{8'hC0, 4,   0, 8'hA5, 13}   // R13
  };

  // watchdog
  initial begin
    #(200000 * 8);
    if (!finished) begin
      failCount++;
      checkCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [7:0] curCtrl;
    int         mism;
    int         fsCnt;
    logic [7:0] e;

    // R1 reset state
    repeat (5) @(negedge clk);
    chk("R1", outByte, 8'h00, "byte in reset");
    chk("R1", {7'd0, outFrameStart}, 8'h00, "frame marker in reset");
    @(posedge clk); #1 rstN = 1'b1;

    curCtrl = 8'h00;
    waitFrames(2);
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].ctrl != curCtrl) begin
        curCtrl = VECS[v].ctrl;
        applyCtrl(curCtrl);
      end
      chk($sformatf("R%0d", VECS[v].tag), doneBuf[idxOf(VECS[v].row, VECS[v].col)],
          VECS[v].exp, $sformatf("ctrl 0x%02h row %0d col %0d",
          VECS[v].ctrl, VECS[v].row + 1, VECS[v].col + 1));
    end

    // R2 frame marker alignment
    applyCtrl(8'h00);
    fsCnt = 0;
    for (int i = 0; i < FRAME; i++) fsCnt += int'(doneFs[i]);
    chk("R2", {7'd0, doneFs[0]}, 8'h01, "marker on first byte");
    chk("R2", 8'(fsCnt), 8'h01, "markers per frame");

    // R8 whole-frame scrambling
    applyCtrl(8'h04);
    mism = 0;
    for (int i = 0; i < FRAME; i++) begin
      e = (i < 9) ? DATA : (DATA ^ keyRef[i-9]);
      if (doneBuf[i] !== e) mism++;
    end
    chk("R8", 8'(mism), 8'h00, "scrambled bytes differing");

    // R9 AIS and scrambling together
    applyCtrl(8'h14);
    mism = 0;
    for (int i = 0; i < FRAME; i++) begin
      if (i < 9) e = DATA;
      else if ((i / COLS) < 3 && (i % COLS) < 9) e = DATA ^ keyRef[i-9];
      else e = 8'hFF ^ keyRef[i-9];
      if (doneBuf[i] !== e) mism++;
    end
    chk("R9", 8'(mism), 8'h00, "AIS plus scramble bytes differing");

    // R10 one-shot A1 error
    applyCtrl(8'h00);
    applyCtrl(8'h01);
    chk("R10", doneBuf[0], 8'h5A, "first A1 inverted");
    chk("R10", doneBuf[1], 8'hA5, "second A1 untouched");
    waitFrames(1);
    chk("R10", doneBuf[0], 8'hA5, "A1 error only once");

    // R11 one-shot B2 error
    applyCtrl(8'h02);
    chk("R11", doneBuf[idxOf(4, 0)], 8'hA4, "first B2 LSB inverted");
    chk("R11", doneBuf[idxOf(4, 1)], 8'hA5, "second B2 untouched");
    waitFrames(1);
    chk("R11", doneBuf[idxOf(4, 0)], 8'hA5, "B2 error only once");

    // R12 mid-frame change waits for the boundary
    applyCtrl(8'h00);
    repeat (1300) @(negedge clk);
    ctrlReg = 8'h08;
    waitFrames(1);
    chk("R12", doneBuf[1400], 8'hA5, "byte after mid-frame change");
    chk("R12", doneBuf[FRAME-1], 8'hA5, "last byte of old frame");
    waitFrames(1);
    chk("R12", doneBuf[0], 8'h00, "new frame under loss");
    chk("R3", doneBuf[FRAME-1], 8'h00, "last byte under loss");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule